// File: doc/BRIEF.md
# Two-Wire Slave Shift Unit with Clock Stretching

This block is the slave side of a two-wire serial bus with one data line and one clock line. It never drives a clock of its own. It watches the bus clock and moves data through an 8-bit shift register. A 4-bit edge counter advances on every rising and falling clock edge. When the counter wraps, the block reports that a transfer is complete and holds the clock line low until software lets it go. A start condition also holds the clock low, so software has time to prepare before the first bit. Both bus lines are open-drain: the block only asks to pull a line low and reads back the wired-AND level.

Software frames each transfer by preloading the counter. A preload of 0 gives a full byte of sixteen edges. A preload of 14 gives the single acknowledge bit of two edges. With the transmit enable set, the register's top bit pulls the data line low when it is 0. Software loads a 0 there to drive an acknowledge or to send a byte. Address matching and the read/write direction are left to software.

Top module: `tw_shift_slave`

## Requirements
- R1: After reset, all three flags are 0, neither line is pulled low, the counter reads 0 and the data register reads 0.
- R2: A start condition (data line falling while the clock line is high) sets the start flag, clears the counter and pulls the clock line low on the following cycle. The counter clear takes priority over a counter preload in the same cycle.
- R3: A stop condition (data line rising while the clock line is high) sets the stop flag without pulling the clock low. A stop-clear strobe clears the flag, and a new stop in the same cycle wins.
- R4: While the clock is not held, each synchronized rising or falling clock edge adds 1 to the counter.
- R5: On a rising clock edge the data line level is sampled. On the next falling edge the data register shifts left by one (toward bit 7) and the sampled bit enters bit 0.
- R6: An edge taken while the counter reads 15 wraps it to 0, sets the overflow flag and pulls the clock line low.
- R7: A hold-release strobe clears the start and overflow flags and stops pulling the clock line low from the next cycle on, unless a new start or overflow arrives in the same cycle.
- R8: While the clock line is held, bus clock edges neither shift the data register nor step the counter, and the bus clock stays low even if the master releases it.
- R9: The data line is pulled low exactly when the transmit enable is 1 and bit 7 of the data register is 0.
- R10: A data write or counter preload strobe loads the register on the next clock. It takes priority over a bus edge in the same cycle, and a preload cancels any overflow from that edge.
- R11: A counter preload of 14 followed by one bus clock pulse (two edges) produces an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Wired-AND level of the bus clock line |
| sda_in | input | 1 | Wired-AND level of the bus data line |
| scl_drive_low | output | 1 | Pull-down enable for the clock line (clock hold) |
| sda_drive_low | output | 1 | Pull-down enable for the data line |
| tx_en | input | 1 | Lets bit 7 of the data register drive the data line |
| wr_data | input | 1 | Strobe: load wdata into the data register |
| wdata | input | 8 | Data register write value |
| wr_cnt | input | 1 | Strobe: load cnt_wdata into the edge counter |
| cnt_wdata | input | 4 | Edge counter preload value |
| hold_release | input | 1 | Strobe: clear start/overflow flags and release the clock |
| stop_clr | input | 1 | Strobe: clear the stop flag |
| rd_data | output | 8 | Current data register contents |
| cnt_val | output | 4 | Current edge counter value |
| start_flag | output | 1 | Start condition seen, clock held |
| ovf_flag | output | 1 | Counter overflow seen, clock held |
| stop_flag | output | 1 | Stop condition seen |

## Verification
The assertions assume the bus lines change slowly compared with the system clock. They also assume the data line only changes while the clock line is high when a start or stop is meant. Otherwise the synchronizer delay could merge a clock edge with a start or stop in one cycle. The bench master holds every bus level for several system cycles and changes the data line only while the clock is low, except for its start and stop sequences. Software strobes are given only while the clock line is low, so a write never lands in the same cycle as a counted edge.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int TWS_DATA_W = 8;
    localparam int TWS_CNT_W  = 4;
    localparam int TWS_SYNC_N = 2;

    // decoded bus events, one cycle wide each
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } tws_ev_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
    end

    // idle bus is high, so flops reset to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign d_out = sync_q.pipe[STAGES-1];

endmodule

// File: rtl/tws_cond_detect.sv
module tws_cond_detect
    import tws_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output tws_ev_t ev
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;

        ev          = '0;
        ev.scl_rise = scl_s & ~prev_q.scl;
        ev.scl_fall = ~scl_s & prev_q.scl;
        // data transitions only count as conditions with clock steady high
        ev.start    = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
        ev.stop     = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              hold,
    input  logic              sda_s,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_cnt,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf_ev
);

    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic              samp;
    } shf_t;

    shf_t shf_d, shf_q;
    logic edge_ok;

    always_comb begin
        shf_d   = shf_q;
        edge_ok = ~hold & (scl_rise | scl_fall);
        ovf_ev  = 1'b0;

        if (edge_ok) begin
            shf_d.cnt = shf_q.cnt + CNT_ONE;
            ovf_ev    = (shf_q.cnt == CNT_LAST);
            if (scl_rise) shf_d.samp = sda_s;
            if (scl_fall) shf_d.data = {shf_q.data[DATA_W-2:0], shf_q.samp};
        end

        // software writes beat bus edges
        if (wr_data) shf_d.data = wdata;
        if (wr_cnt) begin
            shf_d.cnt = cnt_wdata;
            ovf_ev    = 1'b0;
        end

        // start condition restarts framing
        if (start_ev) shf_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign data = shf_q.data;
    assign cnt  = shf_q.cnt;

endmodule

// File: rtl/tws_hold.sv
module tws_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ev,
    input  logic stop_ev,
    input  logic ovf_ev,
    input  logic hold_release,
    input  logic stop_clr,
    output logic start_flag,
    output logic ovf_flag,
    output logic stop_flag,
    output logic hold
);

    typedef struct packed {
        logic start_f;
        logic ovf_f;
        logic stop_f;
    } flag_t;

    flag_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (hold_release) begin
            flg_d.start_f = 1'b0;
            flg_d.ovf_f   = 1'b0;
        end
        if (stop_clr) flg_d.stop_f = 1'b0;
        // new events win over clears
        if (start_ev) flg_d.start_f = 1'b1;
        if (ovf_ev)   flg_d.ovf_f   = 1'b1;
        if (stop_ev)  flg_d.stop_f  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign start_flag = flg_q.start_f;
    assign ovf_flag   = flg_q.ovf_f;
    assign stop_flag  = flg_q.stop_f;
    assign hold       = flg_q.start_f | flg_q.ovf_f;

endmodule

// File: rtl/tw_shift_slave.sv
module tw_shift_slave
    import tws_pkg::*;
#(
    parameter int DATA_W = TWS_DATA_W,
    parameter int CNT_W  = TWS_CNT_W,
    parameter int SYNC_N = TWS_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              tx_en,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_cnt,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              hold_release,
    input  logic              stop_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              stop_flag
);

    localparam int LINE_N = 2;

    logic [LINE_N-1:0] line_s;
    tws_ev_t           ev;
    logic              scl_rise, scl_fall, start_ev, stop_ev, ovf_ev, hold;

    // bit 0 carries the clock line, bit 1 the data line
    tws_sync #(.W(LINE_N), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sda_in, scl_in}),
        .d_out (line_s)
    );

    tws_cond_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (line_s[0]),
        .sda_s (line_s[1]),
        .ev    (ev)
    );

    assign scl_rise = ev.scl_rise;
    assign scl_fall = ev.scl_fall;
    assign start_ev = ev.start;
    assign stop_ev  = ev.stop;

    tws_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .hold      (hold),
        .sda_s     (line_s[1]),
        .wr_data   (wr_data),
        .wdata     (wdata),
        .wr_cnt    (wr_cnt),
        .cnt_wdata (cnt_wdata),
        .data      (rd_data),
        .cnt       (cnt_val),
        .ovf_ev    (ovf_ev)
    );

    tws_hold u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_ev     (start_ev),
        .stop_ev      (stop_ev),
        .ovf_ev       (ovf_ev),
        .hold_release (hold_release),
        .stop_clr     (stop_clr),
        .start_flag   (start_flag),
        .ovf_flag     (ovf_flag),
        .stop_flag    (stop_flag),
        .hold         (hold)
    );

    assign scl_drive_low = hold;
    assign sda_drive_low = tx_en & ~rd_data[DATA_W-1];

endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              scl_rise,
    input logic              ovf_ev,
    input logic              hold_release,
    input logic              wr_data,
    input logic              wr_cnt,
    input logic              scl_drive_low,
    input logic              start_flag,
    input logic              ovf_flag,
    input logic              stop_flag,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [DATA_W-1:0] rd_data
);

    // R2
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (start_flag && scl_drive_low && cnt_val == '0));

    // R3
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> stop_flag);

    // R4
    edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && !scl_drive_low && !wr_cnt && !start_ev)
        |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> (ovf_flag && scl_drive_low && cnt_val == '0));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_release && !start_ev && !ovf_ev) |=> !scl_drive_low);

    // R8
    held_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !wr_data && !wr_cnt && !start_ev)
        |=> ($stable(cnt_val) && $stable(rd_data)));

endmodule

bind tw_shift_slave tws_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .scl_rise      (scl_rise),
    .ovf_ev        (ovf_ev),
    .hold_release  (hold_release),
    .wr_data       (wr_data),
    .wr_cnt        (wr_cnt),
    .scl_drive_low (scl_drive_low),
    .start_flag    (start_flag),
    .ovf_flag      (ovf_flag),
    .stop_flag     (stop_flag),
    .cnt_val       (cnt_val),
    .rd_data       (rd_data)
);

// File: tb/tw_shift_slave_bench.sv
module tw_shift_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       tx_en = 1'b0, wr_data = 1'b0, wr_cnt = 1'b0;
    logic       hold_release = 1'b0, stop_clr = 1'b0;
    logic [7:0] wdata = '0;
    logic [3:0] cnt_wdata = '0;
    logic       scl_drive_low, sda_drive_low, start_flag, ovf_flag, stop_flag;
    logic [7:0] rd_data;
    logic [3:0] cnt_val;
    logic       scl_bus, sda_bus;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];
    logic       ovf_seen = 1'b0;
    logic [7:0] exp_item;

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain wired-AND bus
    assign scl_bus = m_scl & ~scl_drive_low;
    assign sda_bus = m_sda & ~sda_drive_low;

    tw_shift_slave u_tw_shift_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_bus),
        .sda_in        (sda_bus),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .tx_en         (tx_en),
        .wr_data       (wr_data),
        .wdata         (wdata),
        .wr_cnt        (wr_cnt),
        .cnt_wdata     (cnt_wdata),
        .hold_release  (hold_release),
        .stop_clr      (stop_clr),
        .rd_data       (rd_data),
        .cnt_val       (cnt_val),
        .start_flag    (start_flag),
        .ovf_flag      (ovf_flag),
        .stop_flag     (stop_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(input logic [7:0] v);
        wdata = v; wr_data = 1'b1;
        @(negedge clk); wr_data = 1'b0;
    endtask

    task automatic sw_cnt(input logic [3:0] v);
        cnt_wdata = v; wr_cnt = 1'b1;
        @(negedge clk); wr_cnt = 1'b0;
    endtask

    task automatic sw_release();
        hold_release = 1'b1;
        @(negedge clk); hold_release = 1'b0;
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda = b; wait_cyc(4);
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        wait_cyc(SETTLE);
        r = sda_bus;
        m_scl = 1'b0; wait_cyc(SETTLE);
    endtask

    // scoreboard monitor: each new overflow must match the next expected byte
    always @(negedge clk) begin
        if (rst_n) begin
            if (ovf_flag && !ovf_seen) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R5: actual %0h expected none (unexpected overflow)", rd_data);
                end else begin
                    exp_item = exp_q.pop_front();
                    chk("R5 shifted byte", 32'(rd_data), 32'(exp_item));
                end
            end
            ovf_seen = ovf_flag;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic       r;
        logic [7:0] got;
        wait_cyc(3);
        // R1 reset state
        chk("R1 start_flag", 32'(start_flag), 0);
        chk("R1 ovf_flag", 32'(ovf_flag), 0);
        chk("R1 stop_flag", 32'(stop_flag), 0);
        chk("R1 scl_drive_low", 32'(scl_drive_low), 0);
        chk("R1 sda_drive_low", 32'(sda_drive_low), 0);
        chk("R1 cnt_val", 32'(cnt_val), 0);
        chk("R1 rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;
        wait_cyc(SETTLE);

        // R10 preload and write land next cycle
        sw_cnt(4'd5);
        chk("R10 preload", 32'(cnt_val), 5);
        sw_write(8'h5A);
        chk("R10 data write", 32'(rd_data), 32'h5A);

        // R2 start condition
        m_sda = 1'b0; wait_cyc(SETTLE);
        chk("R2 start_flag", 32'(start_flag), 1);
        chk("R2 clock held", 32'(scl_drive_low), 1);
        chk("R2 counter cleared", 32'(cnt_val), 0);
        m_scl = 1'b0; wait_cyc(SETTLE);
        chk("R8 edge ignored while held", 32'(cnt_val), 0);

        // R7 release
        sw_release();
        chk("R7 clock released", 32'(scl_drive_low), 0);
        chk("R7 start_flag cleared", 32'(start_flag), 0);

        // receive 0xA5
        exp_q.push_back(8'hA5);
        got = 8'hA5;
        for (int i = 7; i >= 0; i--) begin
            m_bit(got[i], r);
            if (i == 5) chk("R4 six edges", 32'(cnt_val), 6);
        end
        chk("R6 ovf_flag", 32'(ovf_flag), 1);
        chk("R6 clock held", 32'(scl_drive_low), 1);
        chk("R6 counter wrapped", 32'(cnt_val), 0);

        // R8 master tries to raise clock while held
        m_scl = 1'b1; wait_cyc(10);
        chk("R8 bus clock stretched", 32'(scl_bus), 0);
        chk("R8 data frozen", 32'(rd_data), 32'hA5);
        chk("R8 counter frozen", 32'(cnt_val), 0);
        m_scl = 1'b0; wait_cyc(SETTLE);

        // ACK: drive a 0 for one bit
        sw_write(8'h00);
        tx_en = 1'b1;
        sw_cnt(4'd14);
        chk("R9 ack drives data low", 32'(sda_drive_low), 1);
        exp_q.push_back(8'h00);
        sw_release();
        m_bit(1'b1, r);
        chk("R9 master sees ack", 32'(r), 0);
        chk("R11 overflow after two edges", 32'(ovf_flag), 1);
        chk("R11 counter wrapped", 32'(cnt_val), 0);

        // transmit 0x3C
        sw_write(8'h3C);
        sw_cnt(4'd0);
        chk("R9 msb 0 drives low", 32'(sda_drive_low), 1);
        exp_q.push_back(8'h3C);
        sw_release();
        got = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, r);
            got = {got[6:0], r};
        end
        chk("R9 transmitted byte", 32'(got), 32'h3C);
        chk("R6 ovf after transmit", 32'(ovf_flag), 1);
        tx_en = 1'b0;
        wait_cyc(1);
        chk("R9 no drive without enable", 32'(sda_drive_low), 0);
        sw_release();

        // R3 stop condition
        m_sda = 1'b0; wait_cyc(SETTLE);
        m_scl = 1'b1; wait_cyc(SETTLE);
        m_sda = 1'b1; wait_cyc(SETTLE);
        chk("R3 stop_flag", 32'(stop_flag), 1);
        chk("R3 stop does not hold", 32'(scl_drive_low), 0);
        stop_clr = 1'b1; @(negedge clk); stop_clr = 1'b0;
        chk("R3 stop cleared", 32'(stop_flag), 0);

        chk("R5 scoreboard drained", 32'(exp_q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule